// File: doc/BRIEF.md
# Top-of-Memory SMM Segment Decoder

This block guards a region at the top of system RAM that only System Management Mode code may touch. Two configuration bytes are written through a small config port. The segment byte holds an enable bit and a size code. The SMRAM control byte holds a global enable, a closed bit and a lock. The RAM size in MB and an extended segment size in MB come in as inputs that stay static while the block is running.

Every byte access on the memory port is qualified by an SMM flag. When the guard is armed, a non-SMM access that falls inside the segment never reaches RAM. A read returns 0xFF and a write is dropped. All other accesses, including SMM accesses inside the segment, go straight to RAM unchanged. The routing is combinational, so a read is answered in the cycle it is presented.

Top module: `tseg_decoder`

## Requirements
- R1: After reset both configuration bytes read back as 0x00, and every access passes through to RAM.
- R2: With segment byte bit 0 as enable and bits [2:1] as size code, code 0 selects 1 MB, code 1 selects 2 MB and code 2 selects 8 MB.
- R3: Size code 3 takes the segment size from the `extSizeMb` input.
- R4: The segment covers addresses from (ramTopMb − size) MB up to but not including ramTopMb MB. The byte just below the start and the byte at the top address pass to RAM with their address and data unchanged.
- R5: While the guard is armed, a non-SMM read inside the segment returns 0xFF and does not assert `ramValid`.
- R6: While the guard is armed, a non-SMM write inside the segment is dropped, and the RAM contents stay unchanged.
- R7: An access with `memSmm` high always passes to RAM, even inside an armed segment.
- R8: The guard is armed only when all three of these bits are 1: the segment enable, SMRAM control bit 0 (global enable) and SMRAM control bit 1 (closed). Otherwise every access passes through.
- R9: Writing SMRAM control bit 2 (lock) as 1 freezes both configuration bytes until reset. Only the implemented bits are stored: bits [2:0] of each byte, and the other bits read as 0.
- R10: If the segment size is larger than or equal to ramTopMb, the segment starts at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Config byte write strobe |
| cfgSel | input | 1 | Config select: 0 = segment byte, 1 = SMRAM control byte |
| cfgWrData | input | 8 | Config write data |
| cfgRdData | output | 8 | Read back of the selected config byte |
| ramTopMb | input | ADDR_W-20 | RAM size in MB (top of the segment) |
| extSizeMb | input | ADDR_W-20 | Extended segment size in MB, used when the size code is 3 |
| memValid | input | 1 | Access request |
| memWrite | input | 1 | 1 = write, 0 = read |
| memSmm | input | 1 | Access is made in SMM |
| memAddr | input | ADDR_W | Byte address |
| memWData | input | 8 | Write data |
| memRData | output | 8 | Read data returned to the requester |
| ramValid | output | 1 | Access forwarded to RAM |
| ramWrite | output | 1 | Forwarded access is a write |
| ramAddr | output | ADDR_W | Forwarded address |
| ramWData | output | 8 | Forwarded write data |
| ramRData | input | 8 | Read data from RAM |

## Verification
The hardest case to reach is a dropped write. The port shows nothing when it happens, because the blocked read hides the RAM contents behind 0xFF. To expose it, the bench performs a blocked non-SMM write and then reads the same byte with SMM set, which reveals that the old value is still in RAM. The lock is also awkward to observe. The bench arms the lock with a setting in place, tries to clear both bytes, and confirms through read back and through an access that is still blocked that nothing moved until reset.

// File: rtl/tseg_pkg.sv
package tseg_pkg;
  localparam int MB_SHIFT = 20;
  localparam int SIZE_CODE_W = 2;
  localparam int FIXED_1MB = 1;
  localparam int FIXED_2MB = 2;
  localparam int FIXED_8MB = 8;

  typedef enum logic [SIZE_CODE_W-1:0] {
    SZ_1MB = 2'd0,
    SZ_2MB = 2'd1,
    SZ_8MB = 2'd2,
    SZ_EXT = 2'd3
  } sizeCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      guardOn;
    sizeCode_e sizeCode;
  } tsegStrobe_t;
endpackage

// File: rtl/tseg_ctrl.sv
module tseg_ctrl
  import tseg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        cfgSel,
  input  logic [7:0]  cfgWrData,
  output logic [2:0]  segReg,
  output logic [2:0]  smReg,
  output tsegStrobe_t strobe
);
  logic locked;

  assign locked = smReg[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segReg <= '0;
      smReg  <= '0;
    end else if (cfgWrEn && !locked) begin
      if (cfgSel) smReg  <= cfgWrData[2:0];
      else        segReg <= cfgWrData[2:0];
    end
  end

  always_comb begin
    strobe.guardOn  = segReg[0] & smReg[0] & smReg[1];
    strobe.sizeCode = sizeCode_e'(segReg[2:1]);
  end
endmodule

// File: rtl/tseg_dpath.sv
module tseg_dpath
  import tseg_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int MB_W = ADDR_W - MB_SHIFT
) (
  input  tsegStrobe_t       strobe,
  input  logic [MB_W-1:0]   ramTopMb,
  input  logic [MB_W-1:0]   extSizeMb,
  input  logic              memValid,
  input  logic              memWrite,
  input  logic              memSmm,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memWData,
  output logic [7:0]        memRData,
  output logic              ramValid,
  output logic              ramWrite,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]        ramWData,
  input  logic [7:0]        ramRData
);
  logic [MB_W-1:0] sizeMb;
  logic [MB_W-1:0] baseMb;
  logic [MB_W-1:0] addrMb;
  logic            inSeg;
  logic            blocked;

  always_comb begin
    unique case (strobe.sizeCode)
      SZ_1MB:  sizeMb = MB_W'(FIXED_1MB);
      SZ_2MB:  sizeMb = MB_W'(FIXED_2MB);
      SZ_8MB:  sizeMb = MB_W'(FIXED_8MB);
      default: sizeMb = extSizeMb;
    endcase
  end

  assign baseMb  = (sizeMb >= ramTopMb) ? '0 : ramTopMb - sizeMb;
  assign addrMb  = memAddr[ADDR_W-1:MB_SHIFT];
  assign inSeg   = (addrMb >= baseMb) && (addrMb < ramTopMb);
  assign blocked = strobe.guardOn && inSeg && !memSmm;

  assign ramValid = memValid && !blocked;
  assign ramWrite = memValid && memWrite && !blocked;
  assign ramAddr  = memAddr;
  assign ramWData = memWData;
  assign memRData = blocked ? 8'hFF : ramRData;
endmodule

// File: rtl/tseg_decoder.sv
module tseg_decoder
  import tseg_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int MB_W = ADDR_W - MB_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic [MB_W-1:0]   ramTopMb,
  input  logic [MB_W-1:0]   extSizeMb,
  input  logic              memValid,
  input  logic              memWrite,
  input  logic              memSmm,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memWData,
  output logic [7:0]        memRData,
  output logic              ramValid,
  output logic              ramWrite,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]        ramWData,
  input  logic [7:0]        ramRData
);
  tsegStrobe_t strobe;
  logic [2:0]  segReg;
  logic [2:0]  smReg;

  tseg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .segReg(segReg), .smReg(smReg), .strobe(strobe)
  );

  tseg_dpath #(.ADDR_W(ADDR_W)) dpath_i (
    .strobe(strobe), .ramTopMb(ramTopMb), .extSizeMb(extSizeMb),
    .memValid(memValid), .memWrite(memWrite), .memSmm(memSmm),
    .memAddr(memAddr), .memWData(memWData), .memRData(memRData),
    .ramValid(ramValid), .ramWrite(ramWrite), .ramAddr(ramAddr),
    .ramWData(ramWData), .ramRData(ramRData)
  );

  assign cfgRdData = {5'b0, cfgSel ? smReg : segReg};
endmodule

// File: rtl/tseg_decoder_chk.sv
module tseg_decoder_chk
  import tseg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input tsegStrobe_t       strobe,
  input logic [2:0]        segReg,
  input logic [2:0]        smReg,
  input logic              memValid,
  input logic              memWrite,
  input logic              memSmm,
  input logic [ADDR_W-1:0] memAddr,
  input logic [7:0]        memRData,
  input logic              ramValid,
  input logic              ramWrite,
  input logic [ADDR_W-1:0] ramAddr
);
  assert_pass_addr_R4: assert property (@(posedge clk) disable iff (!rstN)
    ramValid |-> ramAddr == memAddr);

  assert_blocked_read_ff_R5: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memWrite && !ramValid |-> memRData == 8'hFF);

  assert_write_only_forwarded_R6: assert property (@(posedge clk) disable iff (!rstN)
    ramWrite |-> memWrite && ramValid);

  assert_smm_passes_R7: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memSmm |-> ramValid);

  assert_unarmed_passes_R8: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !strobe.guardOn |-> ramValid);

  assert_lock_freezes_R9: assert property (@(posedge clk) disable iff (!rstN)
    smReg[2] && cfgWrEn |=> $stable(segReg) && $stable(smReg));
endmodule

bind tseg_decoder tseg_decoder_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .strobe(strobe),
  .segReg(segReg), .smReg(smReg), .memValid(memValid), .memWrite(memWrite),
  .memSmm(memSmm), .memAddr(memAddr), .memRData(memRData),
  .ramValid(ramValid), .ramWrite(ramWrite), .ramAddr(ramAddr)
);

// File: tb/tseg_decoder_tb_top.sv
module tseg_decoder_tb_top;
  localparam int ADDR_W = 32;
  localparam int MB_W = ADDR_W - 20;

  logic clk = 0;
  logic rstN = 0;
  logic cfgWrEn = 0, cfgSel = 0;
  logic [7:0] cfgWrData = 0, cfgRdData;
  logic [MB_W-1:0] ramTopMb = 12'd128, extSizeMb = 12'd16;
  logic memValid = 0, memWrite = 0, memSmm = 0;
  logic [ADDR_W-1:0] memAddr = 0, ramAddr;
  logic [7:0] memWData = 0, memRData, ramWData, ramRData;
  logic ramValid, ramWrite;

  int nChecks = 0, nFails = 0;
  logic [7:0] ram [logic [31:0]];

  always #2.5 clk = ~clk;

  tseg_decoder #(.ADDR_W(ADDR_W)) dut_i (.*);

  assign ramRData = ram.exists(ramAddr) ? ram[ramAddr] : 8'h00;
  always @(posedge clk) if (ramValid && ramWrite) ram[ramAddr] = ramWData;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic sel, input logic [7:0] d);
    @(negedge clk); cfgWrEn = 1; cfgSel = sel; cfgWrData = d;
    @(negedge clk); cfgWrEn = 0;
  endtask

  task automatic cfgRead(input logic sel, output logic [7:0] d);
    @(negedge clk); cfgSel = sel; #1 d = cfgRdData;
  endtask

  task automatic memWr(input logic smm, input logic [31:0] a, input logic [7:0] d);
    @(negedge clk); memValid = 1; memWrite = 1; memSmm = smm; memAddr = a; memWData = d;
    @(negedge clk); memValid = 0; memWrite = 0;
  endtask

  task automatic memRd(input logic smm, input logic [31:0] a, output logic [7:0] d);
    @(negedge clk); memValid = 1; memWrite = 0; memSmm = smm; memAddr = a;
    #1 d = memRData;
    memValid = 0;
  endtask

  typedef struct packed {
    logic [7:0]  seg;
    logic [7:0]  sm;
    logic        smm;
    logic [31:0] addr;
    logic        pass;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{8'h01, 8'h03, 1'b0, 32'h07F0_0000, 1'b0, 8'd2},  // R2 1 MB first byte
    '{8'h01, 8'h03, 1'b0, 32'h07EF_FFFF, 1'b1, 8'd4},  // R4 below 1 MB
    '{8'h03, 8'h03, 1'b0, 32'h07E0_0000, 1'b0, 8'd2},  // R2 2 MB
    '{8'h03, 8'h03, 1'b0, 32'h07DF_FFFF, 1'b1, 8'd4},
    '{8'h05, 8'h03, 1'b0, 32'h0780_0000, 1'b0, 8'd2},  // R2 8 MB
    '{8'h05, 8'h03, 1'b0, 32'h077F_FFFF, 1'b1, 8'd4},
    '{8'h07, 8'h03, 1'b0, 32'h0700_0000, 1'b0, 8'd3},  // R3 extended 16 MB
    '{8'h07, 8'h03, 1'b0, 32'h06FF_FFFF, 1'b1, 8'd3},
    '{8'h07, 8'h03, 1'b0, 32'h07FF_FFFF, 1'b0, 8'd5},  // R5 last byte
    '{8'h07, 8'h03, 1'b0, 32'h0800_0000, 1'b1, 8'd4},  // R4 top address
    '{8'h07, 8'h03, 1'b1, 32'h0700_0000, 1'b1, 8'd7},  // R7 SMM
    '{8'h06, 8'h03, 1'b0, 32'h0700_0000, 1'b1, 8'd8},  // R8 enable off
    '{8'h07, 8'h02, 1'b0, 32'h0700_0000, 1'b1, 8'd8},  // R8 global off
    '{8'h07, 8'h01, 1'b0, 32'h0700_0000, 1'b1, 8'd8}   // R8 not closed
  };

  initial begin : watchdog
    #(5ns * 20000);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] pat;
    string tag;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    cfgRead(0, d); check("R1 seg reset", d, 8'h00);
    cfgRead(1, d); check("R1 smram reset", d, 8'h00);
    memWr(0, 32'h07F0_0000, 8'h11);
    memRd(0, 32'h07F0_0000, d); check("R1 pass after reset", d, 8'h11);

    for (int i = 0; i < NV; i++) begin
      cfgWrite(0, VECS[i].seg);
      cfgWrite(1, VECS[i].sm);
      pat = 8'h40 + 8'(i);
      memWr(VECS[i].smm, VECS[i].addr, pat);
      memRd(VECS[i].smm, VECS[i].addr, d);
      tag = $sformatf("R%0d row %0d", VECS[i].req, i);
      check(tag, d, VECS[i].pass ? pat : 8'hFF);
    end

    // R6 dropped write: seed under SMM, blocked write, SMM read shows old value
    cfgWrite(0, 8'h07); cfgWrite(1, 8'h03);
    memWr(1, 32'h0710_0000, 8'h5A);
    memWr(0, 32'h0710_0000, 8'hA5);
    memRd(0, 32'h0710_0000, d); check("R5 blocked read", d, 8'hFF);
    memRd(1, 32'h0710_0000, d); check("R6 write dropped", d, 8'h5A);

    // R3 extended size follows input
    extSizeMb = 12'd32;
    memWr(0, 32'h06FF_FFFF, 8'h21);
    memRd(0, 32'h06FF_FFFF, d); check("R3 ext 32 MB covers 112 MB-1", d, 8'hFF);

    // R10 segment larger than RAM
    extSizeMb = 12'd200;
    memRd(0, 32'h0000_0010, d); check("R10 clamp to zero", d, 8'hFF);
    extSizeMb = 12'd16;

    // R9 unimplemented bits and lock
    cfgWrite(0, 8'hFF);
    cfgRead(0, d); check("R9 only low bits stored", d, 8'h07);
    cfgWrite(1, 8'h07);
    cfgWrite(0, 8'h00);
    cfgWrite(1, 8'h00);
    cfgRead(0, d); check("R9 seg frozen", d, 8'h07);
    cfgRead(1, d); check("R9 smram frozen", d, 8'h07);
    memRd(0, 32'h07F0_0000, d); check("R9 still blocked", d, 8'hFF);

    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    cfgRead(1, d); check("R9 lock cleared by reset", d, 8'h00);
    cfgWrite(0, 8'h02);
    cfgRead(0, d); check("R9 writable after reset", d, 8'h02);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule